// File: doc/BRIEF.md
# Processor Status Flag Unit

This block keeps the four status flags of a small 8-bit processor core: the global interrupt enable, zero, auxiliary carry and carry. The execute stage hands it the ALU result, the adder's carry and half-carry outputs, a rotate shift-out bit, a bit-instruction result and a two-bit operation class. On a cycle where the flag write strobe is high, the block updates only the flags that this operation class owns and holds the others.

The interrupt enable flag is driven by separate strobes for enable-interrupt, disable-interrupt and interrupt acknowledge. The block also combines the per-source interrupt requests with their mask bits, the enable flag and a non-maskable request into one accept signal. Priority resolution and vectoring are left to the logic that consumes that signal.

Top module: `cpu_status_flags`

## Requirements
- R1: After a synchronous reset, all four flag outputs (ie_o, z_o, ac_o, cy_o) are 0.
- R2: While ie_o is 0, no maskable request asserts irq_accept. A high nmi_req asserts irq_accept in the same cycle whatever the enable and mask state.
- R3: While ie_o is 1, irq_accept is 1 exactly when some source i has irq_req[i]=1 and irq_mask[i]=0 (mask bit 1 blocks that source), or when nmi_req is 1.
- R4: A cycle with di_stb or int_ack high leaves ie_o at 0 after the next rising edge.
- R5: ei_stb alone sets ie_o to 1 after the next edge. If ei_stb coincides with int_ack or di_stb, ie_o ends at 0.
- R6: With flag_we high and op_class 00 (add/subtract) or 01 (logic), z_o becomes 1 when alu_result is zero and 0 otherwise.
- R7: With flag_we high and op_class 00, ac_o takes adder_ac (carry out of bit 3 or borrow into bit 3). For any other class, ac_o is held.
- R8: With flag_we high and op_class 00, cy_o takes adder_cy (carry or borrow out). Under op_class 01, cy_o is held.
- R9: With flag_we high and op_class 10 (rotate), cy_o takes rot_out, and z_o and ac_o are held.
- R10: With flag_we high and op_class 11 (bit operation), cy_o takes bit_res, and z_o and ac_o are held.
- R11: With flag_we low, z_o, ac_o and cy_o keep their values whatever the data inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| flag_we | input | 1 | Write strobe for zero, auxiliary carry and carry |
| op_class | input | 2 | 00 add/sub, 01 logic, 10 rotate, 11 bit operation |
| alu_result | input | DATA_W | Result of the current ALU operation |
| adder_cy | input | 1 | Carry/borrow out of the adder |
| adder_ac | input | 1 | Carry out of bit 3 / borrow into bit 3 |
| rot_out | input | 1 | Bit shifted out by a rotate |
| bit_res | input | 1 | Result bit of a bit-manipulation instruction |
| ei_stb | input | 1 | Enable-interrupt instruction strobe |
| di_stb | input | 1 | Disable-interrupt instruction strobe |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| irq_req | input | N_SRC | Maskable interrupt requests, one per source |
| irq_mask | input | N_SRC | Per-source mask, 1 blocks the source |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_accept | output | 1 | An interrupt may be accepted this cycle |
| ie_o | output | 1 | Interrupt enable flag |
| z_o | output | 1 | Zero flag |
| ac_o | output | 1 | Auxiliary carry flag |
| cy_o | output | 1 | Carry flag |

## Verification
Each flag is a port, so a wrong value in the flag register shows up one edge after the strobe that wrote it. A corrupted interrupt enable shows up even sooner, in the same cycle, as a wrong irq_accept for any unmasked request. The harder faults are cases where a flag is overwritten when it should be held, for example a rotate that clobbers the auxiliary carry. These show up only if the held value differs from what was wrongly written, so the stimulus sequence sets up flag values that conflict with the input each later operation presents.

// File: rtl/cpu_flags_pkg.sv
package cpu_flags_pkg;

    typedef enum logic [1:0] {
        OPC_ADDSUB = 2'b00,
        OPC_LOGIC  = 2'b01,
        OPC_ROTATE = 2'b10,
        OPC_BITOP  = 2'b11
    } op_class_e;

    typedef struct packed {
        logic ie;
        logic z;
        logic ac;
        logic cy;
    } flags_t;

endpackage

// File: rtl/flag_update_calc.sv
module flag_update_calc
    import cpu_flags_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              we,
    input  op_class_e         opc,
    input  logic [DATA_W-1:0] result,
    input  logic              add_cy,
    input  logic              add_ac,
    input  logic              shift_out,
    input  logic              bit_val,
    input  logic              z_cur,
    input  logic              ac_cur,
    input  logic              cy_cur,
    output logic              z_nxt,
    output logic              ac_nxt,
    output logic              cy_nxt
);
    logic res_zero;

    always_comb begin
        res_zero = (result == '0);
        z_nxt    = z_cur;
        ac_nxt   = ac_cur;
        cy_nxt   = cy_cur;
        if (we) begin
            unique case (opc)
                OPC_ADDSUB: begin
                    z_nxt  = res_zero;
                    ac_nxt = add_ac;
                    cy_nxt = add_cy;
                end
                OPC_LOGIC:  z_nxt  = res_zero;
                OPC_ROTATE: cy_nxt = shift_out;
                OPC_BITOP:  cy_nxt = bit_val;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
    parameter int N_SRC = 4
) (
    input  logic             ie,
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] mask,
    input  logic             nmi,
    output logic             accept
);
    logic [N_SRC-1:0] open_src;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign open_src[i] = req[i] & ~mask[i];
    end

    assign accept = nmi | (ie & (|open_src));
endmodule

// File: rtl/cpu_status_flags.sv
module cpu_status_flags
    import cpu_flags_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_SRC  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_we,
    input  logic [1:0]        op_class,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              adder_cy,
    input  logic              adder_ac,
    input  logic              rot_out,
    input  logic              bit_res,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              int_ack,
    input  logic [N_SRC-1:0]  irq_req,
    input  logic [N_SRC-1:0]  irq_mask,
    input  logic              nmi_req,
    output logic              irq_accept,
    output logic              ie_o,
    output logic              z_o,
    output logic              ac_o,
    output logic              cy_o
);
    flags_t    flags_d, flags_q;
    op_class_e opc;
    logic      z_n, ac_n, cy_n;

    assign opc = op_class_e'(op_class);

    flag_update_calc #(.DATA_W(DATA_W)) u_calc (
        .we        (flag_we),
        .opc       (opc),
        .result    (alu_result),
        .add_cy    (adder_cy),
        .add_ac    (adder_ac),
        .shift_out (rot_out),
        .bit_val   (bit_res),
        .z_cur     (flags_q.z),
        .ac_cur    (flags_q.ac),
        .cy_cur    (flags_q.cy),
        .z_nxt     (z_n),
        .ac_nxt    (ac_n),
        .cy_nxt    (cy_n)
    );

    irq_accept_gate #(.N_SRC(N_SRC)) u_gate (
        .ie     (flags_q.ie),
        .req    (irq_req),
        .mask   (irq_mask),
        .nmi    (nmi_req),
        .accept (irq_accept)
    );

    always_comb begin
        flags_d    = flags_q;
        flags_d.z  = z_n;
        flags_d.ac = ac_n;
        flags_d.cy = cy_n;
        if (int_ack || di_stb) begin
            flags_d.ie = 1'b0;
        end else if (ei_stb) begin
            flags_d.ie = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign ie_o = flags_q.ie;
    assign z_o  = flags_q.z;
    assign ac_o = flags_q.ac;
    assign cy_o = flags_q.cy;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (flags_q == '0)); // R1
    AST_DI_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!ie_o && !nmi_req) |-> !irq_accept); // R2
    AST_NMI_PASSES: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> irq_accept); // R2
    AST_CLEAR_IE: assert property (@(posedge clk) disable iff (rst)
        (int_ack || di_stb) |=> !ie_o); // R4
    AST_SET_IE: assert property (@(posedge clk) disable iff (rst)
        (ei_stb && !int_ack && !di_stb) |=> ie_o); // R5
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (flag_we && (op_class == 2'b00 || op_class == 2'b01))
        |=> (z_o == ($past(alu_result) == '0))); // R6
    AST_AC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_class != 2'b00) |=> $stable(ac_o)); // R7
    AST_CY_ROTATE: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_class == 2'b10) |=> (cy_o == $past(rot_out))); // R9
    AST_CY_BITOP: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_class == 2'b11) |=> (cy_o == $past(bit_res))); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> ($stable(z_o) && $stable(ac_o) && $stable(cy_o))); // R11
endmodule

// File: tb/tb_cpu_status_flags.sv
module tb_cpu_status_flags;
    localparam int DATA_W = 8;
    localparam int N_SRC  = 4;
    localparam int NVEC   = 9;

    logic              clk = 1'b0;
    logic              rst;
    logic              flag_we;
    logic [1:0]        op_class;
    logic [DATA_W-1:0] alu_result;
    logic              adder_cy, adder_ac, rot_out, bit_res;
    logic              ei_stb, di_stb, int_ack;
    logic [N_SRC-1:0]  irq_req, irq_mask;
    logic              nmi_req;
    logic              irq_accept, ie_o, z_o, ac_o, cy_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    cpu_status_flags #(.DATA_W(DATA_W), .N_SRC(N_SRC)) dut (
        .clk(clk), .rst(rst), .flag_we(flag_we), .op_class(op_class),
        .alu_result(alu_result), .adder_cy(adder_cy), .adder_ac(adder_ac),
        .rot_out(rot_out), .bit_res(bit_res), .ei_stb(ei_stb),
        .di_stb(di_stb), .int_ack(int_ack), .irq_req(irq_req),
        .irq_mask(irq_mask), .nmi_req(nmi_req), .irq_accept(irq_accept),
        .ie_o(ie_o), .z_o(z_o), .ac_o(ac_o), .cy_o(cy_o)
    );

    // {we, op[1:0], result[7:0], cy, ac, rot, bit, exp_z, exp_ac, exp_cy}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 2'b00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R6 R7 R8 add, zero
        {1'b1, 2'b01, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 R8 logic holds ac, cy
        {1'b1, 2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R9 rotate
        {1'b1, 2'b11, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R10 bit op
        {1'b0, 2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R11 no write
        {1'b1, 2'b00, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 R8 subtract
        {1'b1, 2'b01, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 logic zero
        {1'b1, 2'b10, 8'h33, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R9 holds z, ac
        {1'b1, 2'b11, 8'h33, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}  // R10 holds z, ac
    };

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flag_we = 0; op_class = 2'b00; alu_result = 8'hFF;
        adder_cy = 0; adder_ac = 0; rot_out = 0; bit_res = 0;
        ei_stb = 0; di_stb = 0; int_ack = 0;
        irq_req = '0; irq_mask = '0; nmi_req = 0;
    endtask

    task automatic ie_step(input logic ei, input logic di, input logic ack);
        @(negedge clk);
        ei_stb = ei; di_stb = di; int_ack = ack;
        @(negedge clk);
        ei_stb = 0; di_stb = 0; int_ack = 0;
    endtask

    initial begin
        #1500000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(ie_o, 0, "R1 ie"); check(z_o, 0, "R1 z");
        check(ac_o, 0, "R1 ac"); check(cy_o, 0, "R1 cy");

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            flag_we = VEC[i][17]; op_class = VEC[i][16:15];
            alu_result = VEC[i][14:7]; adder_cy = VEC[i][6];
            adder_ac = VEC[i][5]; rot_out = VEC[i][4]; bit_res = VEC[i][3];
            @(negedge clk);
            flag_we = 0;
            check(z_o,  VEC[i][2], "R6/R9/R10/R11 z");
            check(ac_o, VEC[i][1], "R7 ac");
            check(cy_o, VEC[i][0], "R8/R9/R10 cy");
        end

        // interrupt gating with enable clear
        irq_req = 4'b1111; irq_mask = 4'b0000; #1;
        check(irq_accept, 0, "R2 maskable blocked");
        nmi_req = 1; #1;
        check(irq_accept, 1, "R2 nmi accepted");
        nmi_req = 0; irq_req = '0;

        ie_step(1, 0, 0);
        check(ie_o, 1, "R5 ei sets");
        irq_req = 4'b0100; irq_mask = 4'b0100; #1;
        check(irq_accept, 0, "R3 masked source");
        irq_mask = 4'b1011; #1;
        check(irq_accept, 1, "R3 unmasked source");
        irq_req = 4'b1011; irq_mask = 4'b1011; #1;
        check(irq_accept, 0, "R3 all requests masked");
        irq_req = '0; irq_mask = '0; #1;
        check(irq_accept, 0, "R3 no request");

        ie_step(0, 0, 1);
        check(ie_o, 0, "R4 ack clears");
        ie_step(1, 0, 0);
        check(ie_o, 1, "R5 ei sets again");
        ie_step(0, 1, 0);
        check(ie_o, 0, "R4 di clears");
        ie_step(1, 0, 0);
        ie_step(1, 0, 1);
        check(ie_o, 0, "R5 ack beats ei");
        ie_step(1, 1, 0);
        check(ie_o, 0, "R5 di beats ei");

        // reset after a state with flags set
        ie_step(1, 0, 0);
        @(negedge clk);
        flag_we = 1; op_class = 2'b00; alu_result = 8'h00;
        adder_cy = 1; adder_ac = 1;
        @(negedge clk);
        flag_we = 0;
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(ie_o, 0, "R1 ie after reset"); check(z_o, 0, "R1 z after reset");
        check(ac_o, 0, "R1 ac after reset"); check(cy_o, 0, "R1 cy after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule